// File: doc/BRIEF.md
# Receive Character Queue with Trigger Pulses

This block buffers received characters on the receive side of a memory-mapped serial port. Each stored entry is twelve bits wide: an eight-bit character in bits [7:0] and a four-bit error nibble in bits [11:8]. A break is stored as an entry with bit 10 set. The deserializer pushes entries. A read of the data register pops the oldest entry, and that pop also reloads a status nibble. Software clears the nibble by writing the status register.

The queue has two sizes. When the mode input selects queued operation it holds sixteen entries. Otherwise it holds a single entry. Any change of the mode input discards the queue contents, and so does an explicit flush strobe. The block keeps registered empty and full flags and a can-accept output. It also emits one-cycle pulses that tell an interrupt controller to raise or drop the receive request. These pulses depend on the exact entry count, and the trigger level is fixed at one entry.

Top module: `rx_char_queue`

## Requirements
- R1: After a synchronous reset, empty is 1, full is 0, can-accept is 1, the status nibble is 0, both interrupt pulses are 0, and single-entry mode is in effect.
- R2: The capacity is 16 entries while fifo_mode_i is 1 and 1 entry while it is 0. Full is 1 exactly when the count equals that capacity, empty is 1 exactly when the count is 0, and can-accept is 1 exactly when the count is below the capacity.
- R3: Entries leave in the order they arrived. head_o always shows the oldest entry, and empty rises after the last entry is popped.
- R4: A push while the queue is full is dropped. The count, the order and the stored entries do not change, and full stays 1.
- R5: The trigger level is fixed at 1. rxint_set_o pulses for one cycle after a push that brings the count to 1. rxint_clr_o pulses for one cycle after any pop that leaves the count at 0, including a pop of an empty queue.
- R6: On a pop, the status nibble takes bits [11:8] of the entry shown on head_o. A stat_clr_i strobe without a pop clears the nibble to 0. When both happen in the same cycle, the pop wins.
- R7: While in single-entry mode, brk_event_i pushes the entry 12'h400 and sets bit 2 of the status nibble. While in 16-entry mode, brk_event_i has no effect.
- R8: flush_i, or any change of fifo_mode_i, empties the queue at the next edge: empty becomes 1, full becomes 0, and the read position returns to slot 0. A push or pop in that same cycle is discarded.
- R9: When a push and a pop arrive in the same cycle, the pop is applied first and the push second, against the reduced count. Both interrupt pulses may fire in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe from the deserializer |
| push_data_i | input | 12 | Entry to store: error nibble in [11:8], character in [7:0] |
| pop_i | input | 1 | Pop strobe from a data-register read |
| fifo_mode_i | input | 1 | 1 selects 16 entries, 0 selects 1 entry; any change flushes |
| flush_i | input | 1 | Flush request |
| stat_clr_i | input | 1 | Status-register write; clears the nibble |
| brk_event_i | input | 1 | External break event |
| head_o | output | 12 | Oldest stored entry |
| err_stat_o | output | 4 | Latched error nibble |
| rx_empty_o | output | 1 | Queue empty flag |
| rx_full_o | output | 1 | Queue full flag |
| can_accept_o | output | 1 | Another entry fits |
| rxint_set_o | output | 1 | Pulse: raise the receive interrupt |
| rxint_clr_o | output | 1 | Pulse: drop the receive interrupt |

## Verification
The hardest state to reach is a push and a pop in the same cycle while exactly one entry is held. In that cycle the count passes through the trigger level in both directions, so both pulses must fire and the stored entry must be replaced. The stimulus gets there by loading one entry in 16-entry mode and then issuing the paired strobes. Overflow is exercised by filling all sixteen slots before an extra push. In single-entry mode, a second push or a break event meets an already full queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int ENTRY_W  = 12;
    localparam int ERR_W    = 4;
    localparam int CHAR_W   = 8;
    localparam int TRIG_LVL = 1;
    localparam int BRK_ERR  = 2;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [CHAR_W-1:0] ch;
    } rxq_entry_t;

    localparam rxq_entry_t BRK_ENTRY = '{err: 4'b0100, ch: 8'h00};

    function automatic int unsigned eff_depth(input logic mode, input int unsigned full_depth);
        return mode ? full_depth : 1;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  rxq_entry_t       wdata,
    input  logic [PTR_W-1:0] raddr,
    output rxq_entry_t       rdata
);

    rxq_entry_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (we) begin
            slots[waddr] <= wdata;
        end
    end

    assign rdata = slots[raddr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_i,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             mode_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             can_accept_o,
    output logic             set_o,
    output logic             clr_o
);

    logic [CNT_W-1:0] cnt, cnt_p, cnt_n, depth_eff;
    logic [PTR_W-1:0] rd_ptr, ptr_p, mask;
    logic             mode_q, flush_now, pop_dec, push_ok;

    always_comb begin
        depth_eff = CNT_W'(eff_depth(mode_q, DEPTH));
        mask      = mode_q ? PTR_W'(DEPTH - 1) : '0;
        flush_now = flush_i | (mode_i != mode_q);
        pop_dec   = pop_i && (cnt != '0);
        cnt_p     = cnt - CNT_W'(pop_dec);
        ptr_p     = pop_dec ? ((rd_ptr + PTR_W'(1)) & mask) : rd_ptr;
        push_ok   = push_i && (cnt_p < depth_eff) && !flush_now;
        cnt_n     = cnt_p + CNT_W'(push_ok);
    end

    assign wr_en_o      = push_ok;
    assign wr_idx_o     = (ptr_p + PTR_W'(cnt_p)) & mask;
    assign rd_idx_o     = rd_ptr;
    assign mode_o       = mode_q;
    assign can_accept_o = cnt < depth_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            rd_ptr  <= '0;
            mode_q  <= 1'b0;
            empty_o <= 1'b1;
            full_o  <= 1'b0;
            set_o   <= 1'b0;
            clr_o   <= 1'b0;
        end else if (flush_now) begin
            cnt     <= '0;
            rd_ptr  <= '0;
            mode_q  <= mode_i;
            empty_o <= 1'b1;
            full_o  <= 1'b0;
            set_o   <= 1'b0;
            clr_o   <= 1'b0;
        end else begin
            cnt    <= cnt_n;
            rd_ptr <= ptr_p;
            mode_q <= mode_i;
            if (push_ok)
                empty_o <= 1'b0;
            else if (pop_i && cnt_p == '0)
                empty_o <= 1'b1;
            if (push_ok && cnt_n == depth_eff)
                full_o <= 1'b1;
            else if (pop_i)
                full_o <= 1'b0;
            set_o <= push_ok && (cnt_n == CNT_W'(TRIG_LVL));
            clr_o <= pop_i && ((cnt_p + CNT_W'(1)) == CNT_W'(TRIG_LVL));
        end
    end

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(empty_o && full_o));

    a_r2_full_tracks_count: assert property (@(posedge clk) disable iff (rst)
        full_o == (cnt == depth_eff));

    a_r2_empty_tracks_count: assert property (@(posedge clk) disable iff (rst)
        empty_o == (cnt == '0));

    a_r4_overflow_dropped: assert property (@(posedge clk) disable iff (rst)
        (full_o && push_i && !pop_i && !flush_now) |=> (full_o && $stable(cnt) && $stable(rd_ptr)));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (empty_o && !full_o && rd_ptr == '0));

    a_r5_set_at_trigger: assert property (@(posedge clk) disable iff (rst)
        set_o |-> (cnt == CNT_W'(TRIG_LVL)));

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pop_i,
    input  logic [ERR_W-1:0] head_err_i,
    input  logic             clr_i,
    input  logic             brk_i,
    output logic [ERR_W-1:0] err_o
);

    logic [ERR_W-1:0] err_n;

    always_comb begin
        err_n = err_o;
        if (clr_i) err_n = '0;
        if (pop_i) err_n = head_err_i;
        if (brk_i) err_n[BRK_ERR] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) err_o <= '0;
        else     err_o <= err_n;
    end

    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !pop_i && !brk_i) |=> (err_o == '0));

    a_r6_pop_loads: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !brk_i) |=> (err_o == $past(head_err_i)));

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_i,
    input  logic [11:0] push_data_i,
    input  logic        pop_i,
    input  logic        fifo_mode_i,
    input  logic        flush_i,
    input  logic        stat_clr_i,
    input  logic        brk_event_i,
    output logic [11:0] head_o,
    output logic [3:0]  err_stat_o,
    output logic        rx_empty_o,
    output logic        rx_full_o,
    output logic        can_accept_o,
    output logic        rxint_set_o,
    output logic        rxint_clr_o
);

    localparam int PTR_W = $clog2(DEPTH);

    logic             mode_cur, brk_push, push_any, wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    rxq_entry_t       wr_entry, rd_entry;

    assign brk_push = brk_event_i && !mode_cur;
    assign push_any = push_i || brk_push;
    assign wr_entry = brk_push ? BRK_ENTRY : rxq_entry_t'(push_data_i);
    assign head_o   = rd_entry;

    rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst(rst), .mode_i(fifo_mode_i), .flush_i(flush_i),
        .push_i(push_any), .pop_i(pop_i), .mode_o(mode_cur),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .rd_idx_o(rd_idx),
        .empty_o(rx_empty_o), .full_o(rx_full_o), .can_accept_o(can_accept_o),
        .set_o(rxint_set_o), .clr_o(rxint_clr_o)
    );

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_idx), .wdata(wr_entry),
        .raddr(rd_idx), .rdata(rd_entry)
    );

    rxq_status status_i (
        .clk(clk), .rst(rst), .pop_i(pop_i), .head_err_i(rd_entry.err),
        .clr_i(stat_clr_i), .brk_i(brk_push), .err_o(err_stat_o)
    );

    a_r2_accept_vs_full: assert property (@(posedge clk) disable iff (rst)
        can_accept_o == !rx_full_o);

    a_r7_break_sets_bit: assert property (@(posedge clk) disable iff (rst)
        (brk_event_i && !mode_cur && !flush_i && fifo_mode_i == mode_cur) |=> err_stat_o[2]);

endmodule

// File: tb/rx_char_queue_tb_top.sv
module rx_char_queue_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push = 1'b0, pop = 1'b0, mode = 1'b0, flush = 1'b0, sclr = 1'b0, brk = 1'b0;
    logic [11:0] pdata = '0;
    logic [11:0] head;
    logic [3:0]  err;
    logic        empty, full, accept, iset, iclr;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    rx_char_queue dut_i (
        .clk(clk), .rst(rst), .push_i(push), .push_data_i(pdata), .pop_i(pop),
        .fifo_mode_i(mode), .flush_i(flush), .stat_clr_i(sclr), .brk_event_i(brk),
        .head_o(head), .err_stat_o(err), .rx_empty_o(empty), .rx_full_o(full),
        .can_accept_o(accept), .rxint_set_o(iset), .rxint_clr_o(iclr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic pu, input logic [11:0] d, input logic po,
                       input logic fl, input logic sc, input logic bk);
        @(negedge clk);
        push = pu; pdata = d; pop = po; flush = fl; sclr = sc; brk = bk;
        @(posedge clk);
        #1;
        @(negedge clk);
        push = 0; pop = 0; flush = 0; sclr = 0; brk = 0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        mode = m;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 accept", accept, 1);
        chk("R1 err", err, 0);
        chk("R1 pulses", {iset, iclr}, 0);
    endtask

    task automatic t_fill_drain;
        set_mode(1);
        chk("R8 mode change empty", empty, 1);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); push = 1; pdata = 12'h0A0 + 12'(i);
            @(posedge clk); #1;
            if (i == 0) chk("R5 set pulse on first push", iset, 1);
            if (i == 1) chk("R5 no set on second push", iset, 0);
            if (i == 14) chk("R2 not full at 15", full, 0);
            @(negedge clk); push = 0;
        end
        chk("R2 full at 16", full, 1);
        chk("R2 accept low at 16", accept, 0);
        cyc(1, 12'hFFF, 0, 0, 0, 0);
        chk("R4 full after overflow", full, 1);
        chk("R4 head after overflow", head, 12'h0A0);
        for (int i = 0; i < 16; i++) begin
            chk("R3 order", head, 12'h0A0 + 12'(i));
            cyc(0, 0, 1, 0, 0, 0);
            if (i == 0) chk("R2 full clears on pop", full, 0);
            if (i < 15) chk("R5 no clr mid drain", iclr, 0);
        end
        chk("R5 clr pulse at zero", iclr, 1);
        chk("R3 empty after drain", empty, 1);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R5 clr one cycle", iclr, 0);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R5 clr on empty pop", iclr, 1);
    endtask

    task automatic t_status;
        cyc(1, 12'h5AB, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R6 pop loads nibble", err, 4'h5);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R6 clear", err, 0);
        cyc(1, 12'h3CD, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 1, 0);
        chk("R6 pop beats clear", err, 4'h3);
        cyc(0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_pushpop;
        cyc(1, 12'h0A1, 0, 0, 0, 0);
        cyc(1, 12'h0B2, 1, 0, 0, 0);
        chk("R9 both pulses", {iset, iclr}, 2'b11);
        chk("R9 head replaced", head, 12'h0B2);
        chk("R9 not empty", empty, 0);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R9 empty after", empty, 1);
    endtask

    task automatic t_flush;
        cyc(1, 12'h011, 0, 0, 0, 0);
        cyc(1, 12'h022, 0, 0, 0, 0);
        cyc(1, 12'h033, 0, 1, 0, 0);
        chk("R8 flush empty", empty, 1);
        chk("R8 flush accept", accept, 1);
        cyc(1, 12'h044, 0, 0, 0, 0);
        chk("R8 slot restart", head, 12'h044);
        cyc(1, 12'h055, 0, 0, 0, 0);
        set_mode(0);
        chk("R8 mode change flush", empty, 1);
        chk("R8 mode change full", full, 0);
    endtask

    task automatic t_single;
        cyc(1, 12'h066, 0, 0, 0, 0);
        chk("R2 single full", full, 1);
        chk("R2 single accept", accept, 0);
        cyc(1, 12'h077, 0, 0, 0, 0);
        chk("R4 single drop", head, 12'h066);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R2 single empty", empty, 1);
    endtask

    task automatic t_break;
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R7 break entry", head, 12'h400);
        chk("R7 break full", full, 1);
        chk("R7 break bit", err, 4'h4);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R7 popped break nibble", err, 4'h4);
        cyc(0, 0, 0, 0, 1, 0);
        set_mode(1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R7 break ignored empty", empty, 1);
        chk("R7 break ignored err", err, 0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(posedge clk); #1;
        t_reset();
        t_fill_drain();
        t_status();
        t_pushpop();
        t_flush();
        t_single();
        t_break();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule